// File: doc/BRIEF.md
# Audio DAC Clock Front-End

This block turns the master clock of an audio converter into a 256fs timebase and keeps a sample-slot counter on that timebase in step with the frame clock (LRCK). A rate select input states how fast the master clock runs. At 256fs every master-clock cycle is a timebase tick. At 384fs a pulse-swallowing stage keeps two of every three cycles, which gives the same 256fs tick rate. The tick is a clock enable on the master clock, so no second clock domain exists.

The frame clock is synchronous to the master clock, but its phase is arbitrary. It passes through a two-flop synchronizer, and each rising edge is checked against the slot counter. The counter is expected to read a fixed compensating value when an edge is processed. If it does not, the counter realigns itself and raises a one-cycle resync flag, so only a power-on reset is ever needed. A lock output reports two consecutive aligned frames. While the active-low power-down input is low, every register keeps its value, because the external clocks may be absent.

No data stream crosses this block, so it has no valid/ready interface and no back-pressure. All pins are plain control and status signals.

Top module: `audio_timebase`

## Requirements
- R1: With rate_sel_i = 0 (256fs master clock) and the block running, tick_o is high in every master-clock cycle.
- R2: With rate_sel_i = 1 (384fs master clock), tick_o follows the repeating pattern high, high, low, starting at the first running cycle after rate_sel_i goes high. tick_o is never low in two running cycles in a row.
- R3: slot_o (8 bits) advances by one, modulo 256, at each clock edge that ends a tick cycle. It holds in every other cycle, except for the realignment of R5.
- R4: A rising edge on lrck_i is sampled into the first synchronizer flop at clock edge n. It is recognised in the cycle that ends at clock edge n+2, counting running edges only. If that cycle is not a tick cycle, the edge stays pending and is handled in the next tick cycle.
- R5: When a recognised edge is handled in a tick cycle, the slot counter is expected to read 2. If it reads 2, it advances normally and resync_o stays low. Otherwise slot_o loads 3 and resync_o is high for exactly the next cycle.
- R6: locked_o rises after two consecutive handled edges that both found slot_o at 2. It falls in the cycle after a misaligned edge, and in the cycle after a tick in which slot_o reads 2 with no edge to handle (a missing frame). locked_o is low whenever resync_o is high.
- R7: While pwdn_ni is low, tick_o and resync_o are low, and slot_o, locked_o and all internal state hold. lrck_i activity during that time is ignored.
- R8: After reset, slot_o = 0, locked_o = 0 and resync_o = 0, and the 384fs pattern restarts at its first high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (256fs or 384fs) |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| pwdn_ni | input | 1 | Power-down, active low; low freezes all state |
| rate_sel_i | input | 1 | 0: master clock is 256fs, 1: master clock is 384fs |
| lrck_i | input | 1 | Frame clock, synchronous but of arbitrary phase |
| tick_o | output | 1 | 256fs timebase enable |
| slot_o | output | 8 | Sample-slot counter within the frame |
| resync_o | output | 1 | One-cycle pulse after a realignment |
| locked_o | output | 1 | Two consecutive aligned frames seen |

## Verification
The case that needs care is a recognised frame edge that lands in a cycle the 2/3 stage swallows. The edge must then wait and be handled by the next tick instead of being lost or handled twice. The bench provokes this by running the 384fs mode at three LRCK phase offsets, one per position in the three-cycle pattern. Each offset is judged two ways. A behavioural reference compares tick_o, slot_o, resync_o and locked_o with the design on every clock. Lock must also be regained at every offset.

// File: rtl/audio_timebase_pkg.sv
package audio_timebase_pkg;

  typedef enum logic {
    RATE_256 = 1'b0,
    RATE_384 = 1'b1
  } rate_e;

  typedef enum logic [1:0] {
    PH_KEEP0 = 2'd0,
    PH_KEEP1 = 2'd1,
    PH_DROP  = 2'd2
  } swallow_ph_e;

endpackage

// File: rtl/audio_timebase_rate_gate.sv
module audio_timebase_rate_gate
  import audio_timebase_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sel_i,
  output logic tick_o
);

  swallow_ph_e ph_q;
  rate_e       rate;

  assign rate = rate_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_KEEP0;
    end else if (run_i) begin
      if (rate == RATE_384) begin
        case (ph_q)
          PH_KEEP0: ph_q <= PH_KEEP1;
          PH_KEEP1: ph_q <= PH_DROP;
          default:  ph_q <= PH_KEEP0;
        endcase
      end else begin
        ph_q <= PH_KEEP0;
      end
    end
  end

  assign tick_o = run_i & ((rate == RATE_256) | (ph_q != PH_DROP));

endmodule

// File: rtl/audio_timebase_edge_sync.sv
module audio_timebase_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = sh_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sh_q[g] <= 1'b0;
      else if (run_i) sh_q[g] <= d;
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/audio_timebase_phase_track.sv
module audio_timebase_phase_track #(
  parameter int CNT_W       = 8,
  parameter int ALIGN_OFS   = 2,
  parameter int LOCK_FRAMES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] slot_o,
  output logic             resync_o,
  output logic             locked_o
);

  localparam int              LK_W   = $clog2(LOCK_FRAMES + 1);
  localparam logic [CNT_W-1:0] OFS    = CNT_W'(ALIGN_OFS);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ALIGN_OFS + 1);
  localparam logic [LK_W-1:0]  GOOD_MAX = LK_W'(LOCK_FRAMES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LK_W-1:0]  good_q, good_d;
  logic             pend_q, pend_d;
  logic             res_q, res_d;
  logic             ev, at_ofs;

  assign ev     = rise_i | pend_q;
  assign at_ofs = (cnt_q == OFS);

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    pend_d = pend_q;
    res_d  = 1'b0;
    if (tick_i) begin
      pend_d = 1'b0;
      if (ev) begin
        if (at_ofs) begin
          cnt_d = cnt_q + 1'b1;
          if (good_q != GOOD_MAX) good_d = good_q + 1'b1;
        end else begin
          cnt_d  = RELOAD;
          good_d = '0;
          res_d  = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (at_ofs) good_d = '0;
      end
    end else if (rise_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      good_q <= '0;
      pend_q <= 1'b0;
      res_q  <= 1'b0;
    end else if (run_i) begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
      pend_q <= pend_d;
      res_q  <= res_d;
    end
  end

  assign slot_o   = cnt_q;
  assign resync_o = res_q & run_i;
  assign locked_o = (good_q == GOOD_MAX);

endmodule

// File: rtl/audio_timebase.sv
module audio_timebase #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ALIGN_OFS   = 2,
  parameter int LOCK_FRAMES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwdn_ni,
  input  logic             rate_sel_i,
  input  logic             lrck_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             resync_o,
  output logic             locked_o
);

  logic tick;
  logic rise;

  audio_timebase_rate_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (pwdn_ni),
    .sel_i  (rate_sel_i),
    .tick_o (tick)
  );

  audio_timebase_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (pwdn_ni),
    .async_i (lrck_i),
    .rise_o  (rise)
  );

  audio_timebase_phase_track #(
    .CNT_W       (CNT_W),
    .ALIGN_OFS   (ALIGN_OFS),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pwdn_ni),
    .tick_i   (tick),
    .rise_i   (rise),
    .slot_o   (slot_o),
    .resync_o (resync_o),
    .locked_o (locked_o)
  );

  assign tick_o = tick;

endmodule

// File: rtl/audio_timebase_chk.sv
module audio_timebase_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwdn_ni,
  input logic             rate_sel_i,
  input logic             tick_o,
  input logic [CNT_W-1:0] slot_o,
  input logic             resync_o,
  input logic             locked_o
);

  a_r1_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwdn_ni && !rate_sel_i) |-> tick_o);

  a_r2_no_double_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwdn_ni && rate_sel_i && !tick_o) |=> (tick_o || !pwdn_ni || !rate_sel_i));

  a_r3_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> ((slot_o == CNT_W'($past(slot_o) + 1'b1)) || resync_o));

  a_r3_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwdn_ni && !tick_o) |=> $stable(slot_o));

  a_r5_resync_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resync_o && pwdn_ni) |=> !resync_o);

  a_r6_unlock_on_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> !locked_o);

  a_r7_pd_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwdn_ni |=> ($stable(slot_o) && $stable(locked_o)));

  a_r7_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwdn_ni |-> (!tick_o && !resync_o));

endmodule

bind audio_timebase audio_timebase_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/audio_timebase_tb_top.sv
`timescale 1ns/1ps
module audio_timebase_tb_top;

  localparam int OFS = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwdn_ni = 1'b1;
  logic       rate_sel_i = 1'b0;
  logic       lrck_i = 1'b0;
  logic       tick_o;
  logic [7:0] slot_o;
  logic       resync_o;
  logic       locked_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  audio_timebase dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwdn_ni(pwdn_ni), .rate_sel_i(rate_sel_i),
    .lrck_i(lrck_i), .tick_o(tick_o), .slot_o(slot_o), .resync_o(resync_o),
    .locked_o(locked_o)
  );

  // behavioural reference
  int m_ph, m_cnt, m_good;
  bit m_pend, m_res;
  bit hist[$];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_good = 0; m_pend = 0; m_res = 0;
      hist = '{0, 0, 0};
    end else if (pwdn_ni) begin
      bit tk, seen, ev;
      tk   = rate_sel_i ? (m_ph != 2) : 1'b1;
      seen = hist[1] && !hist[2];
      ev   = seen || m_pend;
      m_res = 0;
      if (tk) begin
        m_pend = 0;
        if (ev && m_cnt == OFS) begin
          m_good = (m_good < 2) ? m_good + 1 : 2;
          m_cnt  = (m_cnt + 1) % 256;
        end else if (ev) begin
          m_cnt = OFS + 1; m_good = 0; m_res = 1;
        end else begin
          if (m_cnt == OFS) m_good = 0;
          m_cnt = (m_cnt + 1) % 256;
        end
      end else if (seen) begin
        m_pend = 1;
      end
      m_ph = rate_sel_i ? (m_ph + 1) % 3 : 0;
      hist.push_front(lrck_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    int etick;
    etick = pwdn_ni ? (rate_sel_i ? (m_ph != 2) : 1) : 0;
    chk(rate_sel_i ? "R2 tick_o" : "R1 tick_o", tick_o, etick);
    chk("R3 slot_o", slot_o, m_cnt);
    chk("R5 resync_o", resync_o, pwdn_ni ? m_res : 0);
    chk("R6 locked_o", locked_o, m_good == 2);
  endtask

  int cyc = 0;
  int phase = 0;
  bit lr_en = 1;
  int resync_seen = 0;

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      int per;
      @(negedge clk_i);
      cmp_model();
      if (resync_o) resync_seen++;
      cyc++;
      per = rate_sel_i ? 384 : 256;
      lrck_i = lr_en && (((cyc + phase) % per) < per / 2);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int held_slot, held_lock;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R8 reset state
    chk("R8 slot after reset", slot_o, 0);
    chk("R8 locked after reset", locked_o, 0);
    chk("R8 resync after reset", resync_o, 0);
    chk("R8 tick after reset", tick_o, 1);

    // R1, R5, R6: 256fs mode acquires lock
    resync_seen = 0;
    run(256 * 5);
    chk("R5 initial realignment seen", resync_seen > 0, 1);
    chk("R6 lock in 256fs mode", locked_o, 1);

    // R5: phase jump forces a resync, then relock
    phase = 37; resync_seen = 0;
    run(256 * 4);
    chk("R5 resync after phase jump", resync_seen > 0, 1);
    chk("R6 relock after phase jump", locked_o, 1);

    // R6: missing frame edges drop lock
    lr_en = 0;
    run(256 * 2);
    chk("R6 lock lost on missing frame", locked_o, 0);
    lr_en = 1;
    run(256 * 4);
    chk("R6 relock after missing frame", locked_o, 1);

    // R7: power-down freezes state while LRCK keeps toggling
    held_slot = slot_o; held_lock = locked_o;
    pwdn_ni = 1'b0;
    run(300);
    chk("R7 slot held in power-down", slot_o, held_slot);
    chk("R7 lock held in power-down", locked_o, held_lock);
    chk("R7 tick low in power-down", tick_o, 0);
    pwdn_ni = 1'b1;
    run(256 * 4);

    // R2, R4: 384fs mode at three edge positions in the swallow pattern
    rate_sel_i = 1'b1;
    for (int p = 0; p < 3; p++) begin
      phase = 11 + p;
      run(384 * 4);
      chk("R4 lock in 384fs mode at phase step", locked_o, 1);
    end

    // R1: back to 256fs
    rate_sel_i = 1'b0; phase = 5;
    run(256 * 4);
    chk("R1 lock back in 256fs mode", locked_o, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule